// File: doc/BRIEF.md
# Wait-State Memory Responder with Handshake Checker

This block is a word-organised memory that sits on a simple processor bus. The bus has three signals that count here: a one-cycle read request pulse, a one-cycle write request pulse, and a busy flag driven back by the responder. A write stores its data at the moment the request is seen. A read takes its address at the moment the request is seen. Both then run through a wait period whose length comes from a four-bit input. The responder raises busy on the cycle after the request and holds it for that many cycles. It drops busy when the read data is on the output. With a wait count of zero, busy stays low and read data appears on the cycle after the request.

A protocol monitor inside the block watches the master. It sets a sticky flag when a request arrives while busy is high, and a separate sticky flag when read and write are requested in the same cycle. The block drops any request that breaks the rules, so the memory and the timing stay untouched. A synchronous reset clears the handshake state and both flags and leaves the stored words as they are.

Top module: `wsmem_resp`

## Requirements
- R1: An accepted write stores `wr_data` as seen in the request cycle, and changes to `wr_data` in later cycles have no effect on the stored word.
- R2: An accepted read takes its address in the request cycle T and presents the word on `rd_data` in cycle T+W+1, where W is the wait count. `rd_data` then holds that word until the next read completes.
- R3: After an accepted request with W>0, `busy` is low in the request cycle and high for exactly W cycles, starting in the cycle after the request.
- R4: With W=0, `busy` never rises, and a read's data is valid in the cycle after the request.
- R5: A request (read or write) in a cycle with `busy` high sets the sticky flag `err_busy` from the next cycle on. The request is ignored: the memory, `busy` and `rd_data` are unaffected.
- R6: Read and write requests in the same cycle set the sticky flag `err_collide` from the next cycle on. Neither access is performed.
- R7: The two low address bits (byte within a 32-bit word) are ignored, so addresses 4k to 4k+3 reach the same word.
- R8: Address bits above the word index are ignored, so word addresses wrap modulo the depth (default 1024 words).
- R9: A cycle with `rst` high clears `busy`, `err_busy`, `err_collide`, `rd_data` and any pending read, and it leaves the memory contents unchanged.
- R10: The wait count is sampled only in the request cycle. Changing `wait_cnt` while busy does not change when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | One-cycle read request pulse |
| wr_req | input | 1 | One-cycle write request pulse |
| addr | input | ADDR_W (16) | Byte address of the request |
| wr_data | input | DATA_W (32) | Write data, sampled in the request cycle |
| wait_cnt | input | 4 | Wait states for the next request (0 to 15) |
| busy | output | 1 | Access in progress; rises the cycle after a request |
| rd_data | output | DATA_W (32) | Read data, valid when busy falls |
| err_busy | output | 1 | Sticky: request seen while busy |
| err_collide | output | 1 | Sticky: read and write requested together |

## Verification
The hardest case to reach from the ports is a request that lands while busy is high and must leave no trace. The memory, the wait timer and the pending read data must all be unchanged. A well-behaved master never produces this. The stimulus therefore starts a long read, fires a write at the address of another word in the next cycle, and later reads that word back. While busy is high, the bench also keeps changing the write data and the wait count. A reference model of the memory, run cycle by cycle, is compared on every clock with busy, read data and both flags. This exposes any late sampling and any access that should have been ignored.

// File: rtl/wsmem_pkg.sv
package wsmem_pkg;
    localparam int WAIT_W = 4;

    typedef struct packed {
        logic              busy;
        logic [WAIT_W-1:0] left;
        logic              rd_pend;
    } timer_st_t;

    typedef struct packed {
        logic err_busy;
        logic err_collide;
    } proto_st_t;
endpackage

// File: rtl/wsmem_array.sv
module wsmem_array #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    // Storage keeps its contents across reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/wsmem_timer.sv
module wsmem_timer
    import wsmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rd,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              busy,
    output logic              finish_rd
);
    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == WAIT_W'(1)) begin
                st_d.busy    = 1'b0;
                st_d.rd_pend = 1'b0;
            end
        end
        if (start && (wait_cnt != '0)) begin
            st_d.busy    = 1'b1;
            st_d.left    = wait_cnt;
            st_d.rd_pend = start_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign finish_rd = st_q.busy && st_q.rd_pend && (st_q.left == WAIT_W'(1));
endmodule

// File: rtl/wsmem_proto.sv
module wsmem_proto
    import wsmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic busy,
    output logic accept,
    output logic err_busy,
    output logic err_collide
);
    proto_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ((rd_req || wr_req) && busy) begin
            st_d.err_busy = 1'b1;
        end
        if (rd_req && wr_req) begin
            st_d.err_collide = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept      = (rd_req ^ wr_req) && !busy;
    assign err_busy    = st_q.err_busy;
    assign err_collide = st_q.err_collide;
endmodule

// File: rtl/wsmem_resp.sv
module wsmem_resp
    import wsmem_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_busy,
    output logic              err_collide
);
    localparam int BYTE_BITS = $clog2(DATA_W / 8);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] rdata;
    } data_st_t;

    logic                  accept;
    logic                  finish_rd;
    logic [DEPTH_LOG2-1:0] word_idx;
    logic [DATA_W-1:0]     mem_rd;
    logic                  addr_unused;
    data_st_t              dat_d, dat_q;

    // Byte-select bits and bits above the index do not reach the array.
    assign word_idx    = addr[BYTE_BITS +: DEPTH_LOG2];
    assign addr_unused = ^addr;

    wsmem_proto u_proto (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .busy        (busy),
        .accept      (accept),
        .err_busy    (err_busy),
        .err_collide (err_collide)
    );

    wsmem_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_rd  (rd_req),
        .wait_cnt  (wait_cnt),
        .busy      (busy),
        .finish_rd (finish_rd)
    );

    wsmem_array #(
        .DATA_W (DATA_W),
        .IDX_W  (DEPTH_LOG2)
    ) u_array (
        .clk   (clk),
        .we    (accept && wr_req),
        .widx  (word_idx),
        .wdata (wr_data),
        .ridx  (word_idx),
        .rdata (mem_rd)
    );

    always_comb begin
        dat_d = dat_q;
        if (finish_rd) begin
            dat_d.rdata = dat_q.hold;
        end
        if (accept && rd_req) begin
            dat_d.hold = mem_rd;
            if (wait_cnt == '0) begin
                dat_d.rdata = mem_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    assign rd_data = dat_q.rdata;
endmodule

// File: rtl/wsmem_resp_chk.sv
module wsmem_resp_chk #(
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              wr_req,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic              busy,
    input logic              err_busy,
    input logic              err_collide
);
    assert_busy_after_req_R3: assert property (@(posedge clk) disable iff (rst)
        ((rd_req ^ wr_req) && !busy && (wait_cnt != '0)) |=> busy);

    assert_busy_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rd_req || wr_req));

    assert_no_wait_no_busy_R4: assert property (@(posedge clk) disable iff (rst)
        ((rd_req ^ wr_req) && !busy && (wait_cnt == '0)) |=> !busy);

    assert_req_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ((rd_req || wr_req) && busy) |=> err_busy);

    assert_busy_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        err_busy |=> err_busy);

    assert_collide_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |=> err_collide);

    assert_collide_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_collide |=> err_collide);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !err_busy && !err_collide));
endmodule

bind wsmem_resp wsmem_resp_chk #(.WAIT_W(4)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .wait_cnt    (wait_cnt),
    .busy        (busy),
    .err_busy    (err_busy),
    .err_collide (err_collide)
);

// File: tb/wsmem_resp_tb.sv
module wsmem_resp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wait_cnt = '0;
    logic        busy;
    logic [31:0] rd_data;
    logic        err_busy;
    logic        err_collide;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [31:0] ref_mem [DEPTH];
    bit          m_busy = 0;
    int          m_left = 0;
    bit          m_pend = 0;
    logic [31:0] m_hold = '0;
    logic [31:0] m_rdata = '0;
    bit          m_errb = 0;
    bit          m_errc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsmem_resp u_dut (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .addr        (addr),
        .wr_data     (wr_data),
        .wait_cnt    (wait_cnt),
        .busy        (busy),
        .rd_data     (rd_data),
        .err_busy    (err_busy),
        .err_collide (err_collide)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare outputs, drive one cycle of inputs, advance the model past the edge.
    task automatic step(input logic r, input logic w, input logic [15:0] a,
                        input logic [31:0] wd, input logic [3:0] ws, input logic rs);
        bit acc;
        int idx;
        logic [31:0] val;
        chk("R3 busy", {31'b0, busy}, {31'b0, m_busy});
        chk("R2 rd_data", rd_data, m_rdata);
        chk("R5 err_busy", {31'b0, err_busy}, {31'b0, m_errb});
        chk("R6 err_collide", {31'b0, err_collide}, {31'b0, m_errc});
        rd_req = r; wr_req = w; addr = a; wr_data = wd; wait_cnt = ws; rst = rs;
        if (rs) begin
            m_busy = 0; m_left = 0; m_pend = 0; m_hold = '0;
            m_rdata = '0; m_errb = 0; m_errc = 0;
        end else begin
            acc = (r ^ w) && !m_busy;
            if ((r || w) && m_busy) m_errb = 1;
            if (r && w) m_errc = 1;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (m_pend) m_rdata = m_hold;
                    m_pend = 0;
                end
            end
            if (acc) begin
                idx = (int'(a) / 4) % DEPTH;
                val = ref_mem[idx];
                if (w) ref_mem[idx] = wd;
                if (ws == 0) begin
                    if (r) m_rdata = val;
                end else begin
                    m_busy = 1; m_left = int'(ws); m_hold = val; m_pend = r;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'($urandom), $urandom, 4'($urandom), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        step(0, 0, 0, 0, 0, 1);
        // R9: reset state
        chk("R9 reset busy", {31'b0, busy}, 32'd0);
        chk("R9 reset rd_data", rd_data, 32'd0);
        step(0, 0, 0, 0, 0, 0);

        // Fill memory with W=0 writes; R4 busy must stay low (checked per step)
        for (int i = 0; i < DEPTH; i++) step(0, 1, 16'(i * 4), $urandom, 0, 0);

        // R1: write with waits, wr_data changes while busy
        step(0, 1, 16'h0040, 32'hA5A5_0001, 4'd3, 0);
        step(0, 0, 16'h0040, 32'hDEAD_BEEF, 4'd9, 0);
        idle(3);
        step(1, 0, 16'h0040, 0, 4'd2, 0);
        idle(2);
        chk("R1 write data sampled at request", rd_data, 32'hA5A5_0001);

        // R4: zero-wait read, data next cycle
        step(1, 0, 16'h0040, 0, 4'd0, 0);
        chk("R4 zero-wait read", rd_data, 32'hA5A5_0001);
        chk("R4 busy low", {31'b0, busy}, 32'd0);

        // R7: byte-select bits ignored
        step(0, 1, 16'h0103, 32'h7777_0007, 4'd0, 0);
        step(1, 0, 16'h0100, 0, 4'd1, 0);
        idle(1);
        chk("R7 byte bits ignored", rd_data, 32'h7777_0007);

        // R8: wrap modulo depth
        step(0, 1, 16'(DEPTH * 4 + 8), 32'h8888_0008, 4'd0, 0);
        step(1, 0, 16'h0008, 0, 4'd4, 0);
        idle(4);
        chk("R8 address wrap", rd_data, 32'h8888_0008);

        // R10: wait count changes during busy have no effect
        step(1, 0, 16'h0040, 0, 4'd2, 0);
        step(0, 0, 0, 0, 4'd15, 0);
        step(0, 0, 0, 0, 4'd15, 0);
        chk("R10 busy ends after sampled count", {31'b0, busy}, 32'd0);

        // Random legal traffic
        for (int n = 0; n < 4000; n++) begin
            if (m_busy) begin
                idle(1);
            end else begin
                case ($urandom % 3)
                    0: step(1, 0, 16'($urandom), 0, 4'($urandom), 0);
                    1: step(0, 1, 16'($urandom), $urandom, 4'($urandom), 0);
                    default: idle(1);
                endcase
            end
        end
        while (m_busy) idle(1);

        // R5: request while busy is ignored
        step(0, 1, 16'h0200, 32'h1111_2222, 4'd0, 0);
        step(1, 0, 16'h0040, 0, 4'd5, 0);
        step(0, 1, 16'h0200, 32'hBAD0_BAD0, 4'd0, 0);
        chk("R5 err_busy set", {31'b0, err_busy}, 32'd1);
        idle(4);
        chk("R5 busy unaffected", {31'b0, busy}, 32'd0);
        step(1, 0, 16'h0200, 0, 4'd0, 0);
        chk("R5 ignored write", rd_data, 32'h1111_2222);

        // R6: collision performs no access
        step(1, 1, 16'h0200, 32'hC0C0_C0C0, 4'd3, 0);
        chk("R6 err_collide set", {31'b0, err_collide}, 32'd1);
        chk("R6 no busy", {31'b0, busy}, 32'd0);
        step(1, 0, 16'h0200, 0, 4'd0, 0);
        chk("R6 memory unchanged", rd_data, 32'h1111_2222);

        // R9: reset mid-read clears state, keeps memory
        step(1, 0, 16'h0040, 0, 4'd6, 0);
        idle(2);
        step(0, 0, 0, 0, 0, 1);
        chk("R9 flags cleared", {30'b0, err_busy, err_collide}, 32'd0);
        chk("R9 busy cleared", {31'b0, busy}, 32'd0);
        step(1, 0, 16'h0200, 0, 4'd1, 0);
        idle(1);
        chk("R9 memory kept", rd_data, 32'h1111_2222);
        idle(4);

        finish_run();
    end
endmodule